// File: doc/BRIEF.md
# Burst DMA Write Controller

This block copies a fixed-size run of words from an I/O device into memory so the processor does not have to move each word itself. The processor issues one command that gives a word count and a destination word address. The controller then asks the processor for the shared memory bus with a request line and waits for the grant. While it holds the bus, the controller tells the device which chunk offset to present. The device drives those four words onto the shared data bus, and the controller drives the memory address and the write strobe.

When the last chunk is written, the controller drops its request. Once the processor takes the grant back, the controller raises a completion interrupt. The interrupt stays high until the processor clears it. A per-command option makes the controller give up the bus after every chunk, so the processor can reach memory between chunks. In that mode the controller asks for the bus again at once. The usual command moves 12 words in three 4-word writes.

Top module: `dma_burst_mover`

## Requirements
- R1: A command is accepted only while `busy` is low. It moves ceil(`cmd_len`/CHUNK_WORDS) chunk writes, so a 12-word command with CHUNK_WORDS=4 makes exactly 3 writes. No word past the last chunk is written.
- R2: After a command with a non-zero length is accepted, `bus_req` goes high. `mem_wr` stays low until `bus_grant` has been sampled high.
- R3: Chunk k (k = 0, 1, ...) is written in increasing order. It goes to word address `cmd_addr` + k*CHUNK_WORDS, with `dev_offset` = k*CHUNK_WORDS, so memory receives the device's words for offsets 0 to 4*n-1.
- R4: A chunk write counts as done only on a cycle where `mem_wr` and `mem_ready` are both high. Until then, `mem_wr` and `mem_addr` hold steady.
- R5: After the last write, `bus_req` falls. `irq_done` rises only after `bus_grant` has been sampled low, and never while `bus_req` is high.
- R6: With `cmd_chunked`=1, `bus_req` falls after every chunk and rises again for the next one, so it has one high period per chunk. With `cmd_chunked`=0 there is a single high period.
- R7: `mem_wr`, `dev_req` and `mem_addr` are zero unless `bus_req` and `bus_grant` are both high.
- R8: `irq_done` is a level. It stays high until a one-cycle `irq_clear` pulse and is low on the next cycle.
- R9: `busy` is high from the cycle after acceptance until the cycle `irq_done` rises. A command presented while `busy` is high has no effect.
- R10: A zero-length command never raises `bus_req`. It raises `irq_done` two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe from the processor |
| cmd_len | input | LEN_W | Transfer length in words |
| cmd_addr | input | ADDR_W | Destination word address |
| cmd_chunked | input | 1 | 1: release the bus after each chunk |
| bus_grant | input | 1 | Grant from the processor |
| mem_ready | input | 1 | Memory accepts the current write |
| irq_clear | input | 1 | One-cycle interrupt acknowledge |
| bus_req | output | 1 | Request for the shared bus |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address of the chunk |
| dev_req | output | 1 | Tells the device to drive the data bus |
| dev_offset | output | LEN_W | Word offset of the chunk the device must drive |
| busy | output | 1 | Transfer in progress |
| irq_done | output | 1 | Completion interrupt level |

## Verification
The bench builds the controller with ADDR_W=8, LEN_W=5 and CHUNK_WORDS=4. The short address lets one bench array model the whole memory and stamp every written word, so a stray write anywhere shows up. The 5-bit length reaches the largest command, 31 words in eight chunks with a partial last chunk, alongside 0, 1 and the usual 12. A randomly slow grant and a randomly stalled ready line exercise both handshakes in every transfer, in both the whole-burst and the per-chunk release modes.

// File: rtl/dma_burst_mover.sv
module dma_burst_mover #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int CHUNK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_chunked,
  input  logic              bus_grant,
  input  logic              mem_ready,
  input  logic              irq_clear,
  output logic              bus_req,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              dev_req,
  output logic [LEN_W-1:0]  dev_offset,
  output logic              busy,
  output logic              irq_done
);
  localparam int SH = $clog2(CHUNK_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_XFER, S_REL, S_DONE} state_t;

  state_t            st;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  last_q;
  logic [LEN_W-1:0]  idx_q;
  logic              chunked_q;
  logic              irq_q;

  logic [LEN_W:0]    nch;
  logic              owning;
  logic              beat_done;
  logic [LEN_W-1:0]  off_w;

  assign nch       = ({1'b0, cmd_len} + (LEN_W+1)'(CHUNK_WORDS-1)) >> SH;
  assign owning    = (st == S_XFER) && bus_grant;
  assign beat_done = owning && mem_ready;
  assign off_w     = idx_q << SH;

  assign bus_req    = (st == S_REQ) || (st == S_XFER);
  assign mem_wr     = owning;
  assign dev_req    = owning;
  assign dev_offset = owning ? off_w : '0;
  assign mem_addr   = owning ? base_q + ADDR_W'(off_w) : '0;
  assign busy       = (st != S_IDLE);
  assign irq_done   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      chunked_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (cmd_valid) begin
            base_q    <= cmd_addr;
            chunked_q <= cmd_chunked;
            idx_q     <= '0;
            last_q    <= nch[LEN_W-1:0] - LEN_W'(1);
            st        <= (nch == '0) ? S_DONE : S_REQ;
          end
        S_REQ:
          if (bus_grant) st <= S_XFER;
        S_XFER:
          if (beat_done) begin
            if (idx_q == last_q) st <= S_DONE;
            else begin
              idx_q <= idx_q + LEN_W'(1);
              if (chunked_q) st <= S_REL;
            end
          end
        S_REL:
          if (!bus_grant) st <= S_REQ;
        S_DONE:
          if (!bus_grant) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (st == S_DONE && !bus_grant) irq_q <= 1'b1;
    else if (irq_clear) irq_q <= 1'b0;
  end

  // R7
  bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || dev_req) |-> (bus_req && bus_grant));

  // R2
  req_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !mem_wr);

  // R4
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (!bus_grant || (mem_wr && $stable(mem_addr))));

  // R5
  irq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !bus_req);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !irq_clear) |=> irq_done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(base_q));

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_len == '0) |=> !bus_req);
endmodule

// File: tb/sim_dma_burst_mover.sv
module sim_dma_burst_mover;
  localparam int AW = 8, LW = 5, CW = 4, WW = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_chunked = 0, irq_clear = 0;
  logic [LW-1:0] cmd_len = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic bus_grant, mem_ready;
  logic bus_req, mem_wr, dev_req, busy, irq_done;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] dev_offset;

  always #5 clk = ~clk;

  dma_burst_mover #(.ADDR_W(AW), .LEN_W(LW), .CHUNK_WORDS(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
    .cmd_addr(cmd_addr), .cmd_chunked(cmd_chunked), .bus_grant(bus_grant),
    .mem_ready(mem_ready), .irq_clear(irq_clear), .bus_req(bus_req),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .dev_req(dev_req),
    .dev_offset(dev_offset), .busy(busy), .irq_done(irq_done));

  int errors = 0, checks = 0;
  int cur_tag = 0;
  int cur_base = 0;

  function automatic logic [WW-1:0] dev_word(int tag, int idx);
    return {tag[7:0], idx[7:0]} ^ 16'h3C00;
  endfunction

  function automatic int nchunks(int len);
    return (len + CW - 1) / CW;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // processor-side arbiter and memory ready
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_grant <= 1'b0;
      mem_ready <= 1'b0;
    end else begin
      if (bus_req && !bus_grant) begin
        if ($urandom % 3 == 0) bus_grant <= 1'b1;
      end else if (!bus_req && bus_grant) begin
        if ($urandom % 2 == 0) bus_grant <= 1'b0;
      end
      mem_ready <= ($urandom % 4 != 0);
    end
  end

  // device drives the shared data bus
  logic [CW*WW-1:0] dev_data;
  always_comb begin
    dev_data = '0;
    for (int i = 0; i < CW; i++)
      if (dev_req) dev_data[i*WW +: WW] = dev_word(cur_tag, int'(dev_offset) + i);
  end

  // memory model and bus monitor
  logic [WW-1:0] mem [256];
  int stamp [256];
  int wr_total = 0, own_err = 0, ord_err = 0, hold_err = 0, rel_err = 0, br_rise = 0;
  int wr_idx = 0;
  logic prev_stall = 0, prev_br = 0, prev_busy = 0, prev_irq = 0;
  logic [AW-1:0] prev_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) stamp[a] <= -1;
      prev_stall <= 0; prev_br <= 0; prev_busy <= 0; prev_irq <= 0;
    end else begin
      if ((mem_wr || dev_req || mem_addr != '0) && !(bus_req && bus_grant)) own_err <= own_err + 1;
      if (prev_stall && bus_grant && !(mem_wr && mem_addr == prev_addr)) hold_err <= hold_err + 1;
      if (bus_req && !prev_br) br_rise <= br_rise + 1;
      if (irq_done && !prev_irq && (bus_req || bus_grant)) rel_err <= rel_err + 1;
      if (busy && !prev_busy) wr_idx <= 0;
      if (mem_wr && mem_ready) begin
        if (int'(mem_addr) != ((cur_base + wr_idx*CW) % 256) || int'(dev_offset) != wr_idx*CW)
          ord_err <= ord_err + 1;
        for (int i = 0; i < CW; i++) begin
          mem[(int'(mem_addr) + i) % 256] <= dev_data[i*WW +: WW];
          stamp[(int'(mem_addr) + i) % 256] <= cur_tag;
        end
        wr_idx <= wr_idx + 1;
        wr_total <= wr_total + 1;
      end
      prev_stall <= mem_wr && !mem_ready;
      prev_addr  <= mem_addr;
      prev_br    <= bus_req;
      prev_busy  <= busy;
      prev_irq   <= irq_done;
    end
  end

  task automatic run(int base, int len, bit chunked, bit inject);
    int s_wr, s_own, s_ord, s_hold, s_rel, s_br, n, bad, other, waited;
    bit done;
    @(negedge clk);
    cur_tag++;
    cur_base = base;
    n = nchunks(len);
    s_wr = wr_total; s_own = own_err; s_ord = ord_err;
    s_hold = hold_err; s_rel = rel_err; s_br = br_rise;
    cmd_valid = 1; cmd_len = LW'(len); cmd_addr = AW'(base); cmd_chunked = chunked;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1, "R9 busy after accept", busy, 1);
    other = (base + 64) % 192;
    done = 0; waited = 0;
    while (!done && waited < 3000) begin
      if (irq_done) done = 1;
      else begin
        if (inject && waited == 2) begin
          cmd_valid = 1; cmd_len = LW'(8); cmd_addr = AW'(other); cmd_chunked = 0;
        end else cmd_valid = 0;
        @(negedge clk);
        waited++;
      end
    end
    cmd_valid = 0;
    chk(done, "R5 irq raised", int'(done), 1);
    chk(busy == 0, "R9 busy low at irq", busy, 0);
    if (len == 0) chk(waited == 1, "R10 zero-length irq latency", waited + 1, 2);
    chk(wr_total - s_wr == n, "R1 chunk write count", wr_total - s_wr, n);
    bad = 0;
    for (int i = 0; i < n*CW; i++)
      if (stamp[base+i] != cur_tag || mem[base+i] != dev_word(cur_tag, i)) bad++;
    chk(bad == 0, "R3 memory contents", bad, 0);
    chk(ord_err == s_ord, "R3 chunk order and offsets", ord_err - s_ord, 0);
    chk(stamp[base + n*CW] != cur_tag, "R1 no write past last chunk", stamp[base + n*CW], -1);
    chk(own_err == s_own, "R7 bus outputs only while owning", own_err - s_own, 0);
    chk(hold_err == s_hold, "R4 strobe held until ready", hold_err - s_hold, 0);
    chk(rel_err == s_rel, "R5 irq after bus release", rel_err - s_rel, 0);
    if (len == 0) chk(br_rise == s_br, "R10 no bus request", br_rise - s_br, 0);
    else chk(br_rise - s_br == (chunked ? n : 1), "R6 request periods", br_rise - s_br, chunked ? n : 1);
    if (inject) begin
      bad = 0;
      for (int i = 0; i < 8; i++) if (stamp[other+i] == cur_tag && (other+i < base || other+i >= base + n*CW)) bad++;
      chk(bad == 0, "R9 command while busy ignored", bad, 0);
    end
    for (int k = 0; k < int'($urandom % 5); k++) @(negedge clk);
    chk(irq_done == 1, "R8 irq held until clear", irq_done, 1);
    irq_clear = 1;
    @(negedge clk);
    irq_clear = 0;
    chk(irq_done == 0, "R8 irq cleared", irq_done, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_req == 0 && mem_wr == 0, "R7 reset bus idle", bus_req, 0);
    chk(busy == 0 && irq_done == 0, "R9 reset not busy", busy, 0);
    run(16, 12, 0, 0);
    run(100, 12, 1, 0);
    run(40, 0, 0, 0);
    run(60, 1, 0, 0);
    run(200, 31, 1, 0);
    run(120, 12, 0, 1);
    run(10, 31, 0, 1);
    for (int t = 0; t < 24; t++)
      run(int'($urandom % 200), int'($urandom % 32), 1'($urandom), 1'($urandom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule